// File: doc/BRIEF.md
# Saturating Doubling Widening SIMD Multiplier

This block multiplies two 64-bit vectors of signed elements lane by lane. It doubles every product and writes it into a lane twice as wide, so the 128-bit result holds one double-width value per element. Elements are either 16-bit, giving four lanes, or 32-bit, giving two lanes, as selected by a 2-bit size code. The only doubled product that does not fit the wide lane comes from multiplying the most negative element value by itself. In that case the lane is clamped to the largest positive wide value.

In broadcast mode a lane index picks one element of the second operand, and that element multiplies every lane of the first operand. Any clamped lane sets a sticky saturation flag. The flag stays set until a synchronous clear input drops it. Results appear one clock after the input strobe. An unsupported size code raises a one-cycle illegal indication and changes nothing else.

Top module: `sat_dbl_widen_mul`

## Requirements
- R1: Size code 2'b01 selects four signed 16-bit lanes; operand lane e is bits [16e+:16] and result lane e is bits [32e+:32].
- R2: Size code 2'b10 selects two signed 32-bit lanes; operand lane e is bits [32e+:32] and result lane e is bits [64e+:64].
- R3: A result lane equals exactly 2*a*b, computed at full precision, whenever the lane does not saturate.
- R4: When both operand elements hold the most negative element value, the result lane is the largest positive double-width value (32'h7FFFFFFF or 64'h7FFFFFFFFFFFFFFF); no other input pair saturates.
- R5: With scalarMode = 0, lane e of the first operand is multiplied by lane e of the second.
- R6: With scalarMode = 1, the element of the second operand at laneIdx multiplies every lane; for 32-bit lanes only laneIdx[0] is used.
- R7: For a legal size, result and resultValid update on the clock edge that samples inValid; resultValid is high for exactly that one following cycle.
- R8: Size codes 2'b00 and 2'b11 raise illegalSize for one cycle after the strobe, give no resultValid, and leave result and satSticky unchanged.
- R9: satSticky is set by a legal operation in which any lane saturates, and no operation clears it.
- R10: stickyClr clears satSticky synchronously; if a saturating operation is accepted in the same cycle, satSticky ends up set.
- R11: Active-low synchronous reset rstN clears result, resultValid, illegalSize and satSticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Operands and controls are valid this cycle |
| sizeCode | input | 2 | Element size: 01 = 16-bit, 10 = 32-bit, others illegal |
| scalarMode | input | 1 | 1 = broadcast one element of opB |
| laneIdx | input | 2 | Broadcast element index |
| opA | input | 64 | First operand vector |
| opB | input | 64 | Second operand vector |
| stickyClr | input | 1 | Synchronous clear of the saturation flag |
| result | output | 128 | Double-width result vector |
| resultValid | output | 1 | Result updated this cycle |
| illegalSize | output | 1 | Previous strobe carried an illegal size |
| satSticky | output | 1 | Cumulative saturation flag |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the same cycle as a saturating operation. Random operands almost never hit the double-minimum pair. The bench therefore drives that pair on purpose, both in one lane of a mixed vector and through broadcast of an indexed minimum element, and raises stickyClr on the same edge. It also applies an illegal size while the flag is set and the result holds a known value. This shows that neither one moves.

// File: rtl/sdwm_pkg.sv
package sdwm_pkg;
  localparam int SRC_W  = 64;
  localparam int DST_W  = 2 * SRC_W;
  localparam int NARROW = 16;
  localparam int WIDE   = 32;
  localparam int NL_N   = SRC_W / NARROW;
  localparam int NL_W   = SRC_W / WIDE;

  typedef enum logic [1:0] {
    SZ_BAD0 = 2'b00,
    SZ_H16  = 2'b01,
    SZ_W32  = 2'b10,
    SZ_BAD3 = 2'b11
  } sizeSel_t;

  typedef struct packed {
    logic loadResult;
    logic wideLanes;
  } dpStrobe_t;
endpackage

// File: rtl/sdwm_lane.sv
module sdwm_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] y,
  output logic           sat
);
  localparam int FW = 2 * W + 2;
  localparam logic signed [FW-1:0] MAXV = {3'b000, {(2*W-1){1'b1}}};

  logic signed [FW-1:0] extA, extB, prod, dbl;

  always_comb begin
    extA = {{(W+2){a[W-1]}}, a};
    extB = {{(W+2){b[W-1]}}, b};
    prod = extA * extB;
    dbl  = prod <<< 1;
    sat  = dbl > MAXV;
    y    = sat ? MAXV[2*W-1:0] : dbl[2*W-1:0];
  end
endmodule

// File: rtl/sdwm_ctrl.sv
module sdwm_ctrl
  import sdwm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic [1:0] sizeCode,
  input  logic      stickyClr,
  input  logic      anySat,
  output dpStrobe_t strobe,
  output logic      resultValid,
  output logic      illegalSize,
  output logic      satSticky
);
  logic legal;

  always_comb begin
    legal             = (sizeSel_t'(sizeCode) == SZ_H16) || (sizeSel_t'(sizeCode) == SZ_W32);
    strobe.loadResult = inValid && legal;
    strobe.wideLanes  = sizeSel_t'(sizeCode) == SZ_W32;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      illegalSize <= 1'b0;
      satSticky   <= 1'b0;
    end else begin
      resultValid <= strobe.loadResult;
      illegalSize <= inValid && !legal;
      satSticky   <= (satSticky && !stickyClr) || (strobe.loadResult && anySat);
    end
  end

  AST_ILLEGAL_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !(illegalSize && resultValid)); // R8
  AST_STICKY_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(satSticky) |-> $past(stickyClr)); // R9
  AST_SAT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (stickyClr && inValid && legal && anySat) |=> satSticky); // R10
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !$past(inValid)) |-> 1'b0); // R7
endmodule

// File: rtl/sdwm_datapath.sv
module sdwm_datapath
  import sdwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             scalarMode,
  input  logic [1:0]       laneIdx,
  input  logic [SRC_W-1:0] opA,
  input  logic [SRC_W-1:0] opB,
  output logic             anySat,
  output logic [DST_W-1:0] result
);
  logic [NL_N-1:0]  satN;
  logic [NL_W-1:0]  satW;
  logic [DST_W-1:0] resN, resW;

  for (genvar e = 0; e < NL_N; e++) begin : gNarrow
    logic [NARROW-1:0] bSel;
    assign bSel = scalarMode ? opB[NARROW*laneIdx +: NARROW] : opB[NARROW*e +: NARROW];
    sdwm_lane #(.W(NARROW)) uLane (
      .a  (opA[NARROW*e +: NARROW]),
      .b  (bSel),
      .y  (resN[2*NARROW*e +: 2*NARROW]),
      .sat(satN[e])
    );
  end

  for (genvar e = 0; e < NL_W; e++) begin : gWide
    logic [WIDE-1:0] bSel;
    assign bSel = scalarMode ? opB[WIDE*laneIdx[0] +: WIDE] : opB[WIDE*e +: WIDE];
    sdwm_lane #(.W(WIDE)) uLane (
      .a  (opA[WIDE*e +: WIDE]),
      .b  (bSel),
      .y  (resW[2*WIDE*e +: 2*WIDE]),
      .sat(satW[e])
    );
  end

  assign anySat = strobe.wideLanes ? |satW : |satN;

  always_ff @(posedge clk) begin
    if (!rstN)                  result <= '0;
    else if (strobe.loadResult) result <= strobe.wideLanes ? resW : resN;
  end

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadResult |=> $stable(result)); // R8
endmodule

// File: rtl/sat_dbl_widen_mul.sv
module sat_dbl_widen_mul
  import sdwm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        sizeCode,
  input  logic              scalarMode,
  input  logic [1:0]        laneIdx,
  input  logic [SRC_W-1:0]  opA,
  input  logic [SRC_W-1:0]  opB,
  input  logic              stickyClr,
  output logic [DST_W-1:0]  result,
  output logic              resultValid,
  output logic              illegalSize,
  output logic              satSticky
);
  dpStrobe_t strobe;
  logic      anySat;

  sdwm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sizeCode(sizeCode),
    .stickyClr(stickyClr), .anySat(anySat), .strobe(strobe),
    .resultValid(resultValid), .illegalSize(illegalSize), .satSticky(satSticky)
  );

  sdwm_datapath uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .scalarMode(scalarMode),
    .laneIdx(laneIdx), .opA(opA), .opB(opB), .anySat(anySat), .result(result)
  );

  AST_BAD_SIZE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (sizeCode[0] == sizeCode[1]) && !stickyClr) |=> $stable(satSticky)); // R8
endmodule

// File: tb/sat_dbl_widen_mul_test.sv
module sat_dbl_widen_mul_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [1:0]   sizeCode = 2'b01;
  logic         scalarMode = 1'b0;
  logic [1:0]   laneIdx = 2'b00;
  logic [63:0]  opA = '0, opB = '0;
  logic         stickyClr = 1'b0;
  logic [127:0] result;
  logic         resultValid, illegalSize, satSticky;

  int checks = 0;
  int errors = 0;
  logic expSticky = 1'b0;
  logic [127:0] lastRes = '0;

  always #2.5 clk = ~clk;

  sat_dbl_widen_mul uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sizeCode(sizeCode),
    .scalarMode(scalarMode), .laneIdx(laneIdx), .opA(opA), .opB(opB),
    .stickyClr(stickyClr), .result(result), .resultValid(resultValid),
    .illegalSize(illegalSize), .satSticky(satSticky)
  );

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] refCalc(logic [1:0] sz, logic sc, logic [1:0] idx,
                                           logic [63:0] a, logic [63:0] b, output logic sat);
    logic [127:0] r = '0;
    sat = 1'b0;
    if (sz == 2'b01) begin
      for (int e = 0; e < 4; e++) begin
        longint x = longint'($signed(a[16*e +: 16]));
        longint y = sc ? longint'($signed(b[16*idx +: 16])) : longint'($signed(b[16*e +: 16]));
        longint p = 2 * x * y;
        if (p > 64'sd2147483647) begin sat = 1'b1; p = 64'sd2147483647; end
        r[32*e +: 32] = p[31:0];
      end
    end else begin
      for (int e = 0; e < 2; e++) begin
        longint x = longint'($signed(a[32*e +: 32]));
        longint y = sc ? longint'($signed(b[32*idx[0] +: 32])) : longint'($signed(b[32*e +: 32]));
        if (x == -64'sd2147483648 && y == -64'sd2147483648) begin
          sat = 1'b1;
          r[64*e +: 64] = 64'h7FFF_FFFF_FFFF_FFFF;
        end else begin
          longint p = 2 * x * y;
          r[64*e +: 64] = p;
        end
      end
    end
    return r;
  endfunction

  task automatic runOp(string req, logic [1:0] sz, logic sc, logic [1:0] idx,
                       logic [63:0] a, logic [63:0] b, logic clr);
    logic sat;
    logic [127:0] exp;
    logic legal = (sz == 2'b01) || (sz == 2'b10);
    exp = legal ? refCalc(sz, sc, idx, a, b, sat) : lastRes;
    if (!legal) sat = 1'b0;
    @(negedge clk);
    inValid = 1'b1; sizeCode = sz; scalarMode = sc; laneIdx = idx;
    opA = a; opB = b; stickyClr = clr;
    @(negedge clk);
    inValid = 1'b0; stickyClr = 1'b0;
    expSticky = (expSticky && !clr) || (legal && sat);
    check({req, " result"}, result, exp);
    check({req, " valid"}, {127'd0, resultValid}, {127'd0, legal});
    check({req, " illegal"}, {127'd0, illegalSize}, {127'd0, !legal});
    check({req, " sticky"}, {127'd0, satSticky}, {127'd0, expSticky});
    lastRes = exp;
    @(negedge clk);
    check({req, " valid pulse R7"}, {127'd0, resultValid}, 128'd0);
    check({req, " illegal pulse R8"}, {127'd0, illegalSize}, 128'd0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 result", result, '0);
    check("R11 valid", {127'd0, resultValid}, 128'd0);
    check("R11 illegal", {127'd0, illegalSize}, 128'd0);
    check("R11 sticky", {127'd0, satSticky}, 128'd0);
    rstN = 1'b1;
    expSticky = 1'b0;
    lastRes = '0;
  endtask

  task automatic testVector16();
    runOp("R1 R3 R5 v16 small", 2'b01, 1'b0, 2'd0, 64'h0004_FFFD_0002_0001, 64'h0003_0007_FFFF_0005, 1'b0);
    runOp("R1 R3 R5 v16 extremes", 2'b01, 1'b0, 2'd0, 64'h7FFF_8000_7FFF_8000, 64'h7FFF_7FFF_8000_0001, 1'b0);
  endtask

  task automatic testVector32();
    runOp("R2 R3 R5 v32 small", 2'b10, 1'b0, 2'd0, 64'hFFFF_FFF0_0001_2345, 64'h0000_0100_FFFF_FFFF, 1'b0);
    runOp("R2 R3 v32 extremes", 2'b10, 1'b0, 2'd0, 64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000, 1'b0);
  endtask

  task automatic testScalar();
    for (int i = 0; i < 4; i++)
      runOp("R6 scalar16", 2'b01, 1'b1, 2'(i), 64'h1234_8001_FFFF_0102, 64'h7FFF_0003_8001_FFFE, 1'b0);
    runOp("R6 scalar32 idx3 uses lane1", 2'b10, 1'b1, 2'd3, 64'h0000_0003_FFFF_FFFE, 64'h0000_0009_0000_0005, 1'b0);
    runOp("R6 scalar32 idx2 uses lane0", 2'b10, 1'b1, 2'd2, 64'h0000_0003_FFFF_FFFE, 64'h0000_0009_0000_0005, 1'b0);
  endtask

  task automatic testSaturate();
    runOp("R4 R9 sat16 lane2", 2'b01, 1'b0, 2'd0, 64'h0001_8000_8000_0002, 64'h0001_8000_7FFF_0002, 1'b0);
    runOp("R9 sticky holds", 2'b01, 1'b0, 2'd0, 64'h0001_0002_0003_0004, 64'h0005_0006_0007_0008, 1'b0);
    runOp("R8 illegal 00 keeps state", 2'b00, 1'b0, 2'd0, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 1'b0);
    runOp("R8 illegal 11 keeps state", 2'b11, 1'b1, 2'd1, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1'b0);
    runOp("R10 clear alone", 2'b10, 1'b0, 2'd0, 64'h0000_0002_0000_0003, 64'h0000_0004_0000_0005, 1'b1);
    runOp("R4 R10 sat32 with clear", 2'b10, 1'b1, 2'd1, 64'h8000_0000_0000_0001, 64'h8000_0000_1234_5678, 1'b1);
    runOp("R10 clear again", 2'b01, 1'b0, 2'd0, 64'h0, 64'h0, 1'b1);
    runOp("R4 R6 sat16 broadcast min", 2'b01, 1'b1, 2'd3, 64'h8000_0001_8000_7FFF, 64'h8000_0000_0000_0000, 1'b0);
  endtask

  task automatic testRandom();
    for (int i = 0; i < 40; i++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      logic [1:0] sz = (i % 2 == 0) ? 2'b01 : 2'b10;
      runOp("R3 R5 R6 random", sz, 1'(i % 3 == 0), 2'($urandom), a, b, 1'(i % 7 == 0));
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testVector16();
    testVector32();
    testScalar();
    testSaturate();
    testRandom();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule